// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block converts a 32-bit logical address into a physical address. It walks a tree of up to four translation tables held in memory. The run-time configuration comes from a translation control word and two 64-bit root pointers. The supervisor flag of a request picks the root pointer, and the control word sets where each level's index sits in the address. A walk can end at any level when it meets a page descriptor. Tables may hold 4-byte or 8-byte entries. An 8-byte entry can bound the index range of the table below it and can mark its page supervisor-only.

A request is taken when `reqReady` is high. The walker then fetches descriptors through a read port whose data returns one cycle after the strobe. It marks each descriptor it reads as used, and on a successful write it marks the final page descriptor as modified. In both cases it writes the updated first word back through the write port. The result is a single-cycle pulse on `rspValid`. That pulse carries either a physical address with the accumulated write-protect and the page's cache-inhibit bit, or a one-hot fault code.

Field encodings: a descriptor's type sits in bits 1:0 (00 invalid, 01 page, 10 table of 4-byte entries, 11 table of 8-byte entries). Write-protect is bit 2, used is bit 3, modified is bit 4, cache-inhibit is bit 6 and supervisor-only is bit 8 (8-byte entries only). A table base is bits 31:4 and a page base is bits 31:8; in 8-byte entries both come from the second word. The first word of an 8-byte entry holds the index bound in bits 30:16 and the bound direction in bit 31. A root pointer carries its base in bits 31:4, its type in bits 33:32, its bound in bits 62:48 and the bound direction in bit 63. The control word has the level widths A, B, C and D in bits 15:12, 11:8, 7:4 and 3:0, the initial shift in 19:16, and enable in bit 31.

Top module: `table_walker`

## Requirements
- R1: With control bit 31 clear, a request returns `rspPhys` equal to `reqAddr` with no fault, and `rspValid` rises on the cycle after acceptance.
- R2: The root pointer selected by `reqSuper` decides the start. Type 00 gives the invalid fault (`rspFault` bit 0) in one cycle. Type 01 gives physical = (root bits 31:4 shifted up by 4) + logical address, also in one cycle.
- R3: The level-A index is the TIA bits just below the top IS bits of the address, and each lower level's index lies directly below the previous one. A level of width zero and all levels beneath it are not walked. Entry address = table base + index × entry size.
- R4: A page descriptor at any level ends the walk. Physical = page base + the logical bits below the last index consumed.
- R5: For a table of 8-byte entries, the next base or page base comes from the second word, and bit 8 of the first word marks the page supervisor-only.
- R6: Before each fetch, the index is checked against the current bound. If direction bit = 1, an index below the bound faults; if it is 0, an index above the bound faults. The fault is limit (`rspFault` bit 1). A 4-byte entry leaves the next table unbounded.
- R7: An invalid descriptor, or a table descriptor found at the lowest walked level, ends the walk with the invalid fault.
- R8: Write-protect bits of all descriptors read are ORed. A write with the result set gets the write-protect fault (`rspFault` bit 3). A read returns it on `rspWp`.
- R9: A user request that meets a supervisor-only mark gets the supervisor fault (`rspFault` bit 2). This fault takes priority over write-protect.
- R10: Every descriptor read gets bit 3 set in memory, and a successful write also sets bit 4 of the final page descriptor. A word is only rewritten when it changes.
- R11: `rspFault` has at most one bit set, and `rspPhys` is zero on a fault. `reqReady` is high after reset and low while a walk is in progress.
- R12: `rspCi` reports bit 6 of the final page descriptor on a successful table walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWord | input | 32 | Translation control word, sampled when a walk starts |
| userRoot | input | 64 | Root pointer for user requests |
| superRoot | input | 64 | Root pointer for supervisor requests |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and able to take a request |
| reqAddr | input | 32 | Logical address |
| reqWrite | input | 1 | Request is a write |
| reqSuper | input | 1 | Request is from supervisor mode |
| rspValid | output | 1 | One-cycle result pulse |
| rspPhys | output | 32 | Physical address, zero on fault |
| rspFault | output | 4 | One-hot fault: 0 invalid, 1 limit, 2 supervisor, 3 write-protect |
| rspWp | output | 1 | Accumulated write-protect of the walk |
| rspCi | output | 1 | Cache-inhibit of the final page |
| memRdEn | output | 1 | Descriptor read strobe |
| memRdAddr | output | 32 | Descriptor read address |
| memRdData | input | 32 | Read data, valid one cycle after the strobe |
| memWrEn | output | 1 | Descriptor write-back strobe |
| memWrAddr | output | 32 | Write-back address |
| memWrData | output | 32 | Updated descriptor word |

## Verification
The bench builds the walker with its default parameters: a 32-bit address, four levels, 4-bit width fields and a 15-bit bound. Every shift, mask and bound compare is therefore at full width. The bench memory is a 4 KB array whose addresses wrap. Because of that, randomly filled descriptor words always land somewhere in it, so random trees hit every descriptor type, both entry sizes, bounds in both directions and early ends at any level. Random control words vary the initial shift and the number of levels. Directed trees pin exact physical addresses and fault priorities.

// File: rtl/walk_pkg.sv
package walk_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_GET0, S_GET1, S_EVAL
  } walkState_t;

  typedef enum logic [1:0] {
    PH_NONE, PH_PASS, PH_ROOT, PH_PAGE
  } physSel_t;

  localparam logic [1:0] DT_INVALID = 2'b00;
  localparam logic [1:0] DT_PAGE    = 2'b01;

  localparam int BIT_WP    = 2;
  localparam int BIT_USED  = 3;
  localparam int BIT_MOD   = 4;
  localparam int BIT_CI    = 6;
  localparam int BIT_SUP   = 8;
  localparam int TBL_LSB   = 4;
  localparam int PAGE_LSB  = 8;

  localparam logic [3:0] FLT_INVALID = 4'b0001;
  localparam logic [3:0] FLT_LIMIT   = 4'b0010;
  localparam logic [3:0] FLT_SUPER   = 4'b0100;
  localparam logic [3:0] FLT_WPROT   = 4'b1000;

  typedef struct packed {
    logic       load;
    logic       rdWord0;
    logic       rdWord1;
    logic       capW0;
    logic       capW1;
    logic       descend;
    logic       writeBack;
    logic       setMod;
    logic       finish;
    physSel_t   physSel;
    logic [3:0] fault;
  } strobe_t;

  typedef struct packed {
    logic       enable;
    logic [1:0] rootDt;
    logic       limitBad;
    logic       longFmt;
    logic [1:0] descDt;
    logic       lastLevel;
    logic       supBad;
    logic       wpBad;
    logic       isWrite;
  } status_t;

endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  status_t status,
  output strobe_t strobe,
  output logic    reqReady
);

  walkState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign reqReady = (state == S_IDLE);

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          if (!status.enable) begin
            strobe.finish  = 1'b1;
            strobe.physSel = PH_PASS;
          end else if (status.rootDt == DT_INVALID) begin
            strobe.finish = 1'b1;
            strobe.fault  = FLT_INVALID;
          end else if (status.rootDt == DT_PAGE) begin
            strobe.finish  = 1'b1;
            strobe.physSel = PH_ROOT;
          end else begin
            strobe.load = 1'b1;
            nextState   = S_ISSUE;
          end
        end
      end
      S_ISSUE: begin
        if (status.limitBad) begin
          strobe.finish = 1'b1;
          strobe.fault  = FLT_LIMIT;
          nextState     = S_IDLE;
        end else begin
          strobe.rdWord0 = 1'b1;
          nextState      = S_GET0;
        end
      end
      S_GET0: begin
        strobe.capW0 = 1'b1;
        if (status.longFmt) begin
          strobe.rdWord1 = 1'b1;
          nextState      = S_GET1;
        end else begin
          nextState = S_EVAL;
        end
      end
      S_GET1: begin
        strobe.capW1 = 1'b1;
        nextState    = S_EVAL;
      end
      S_EVAL: begin
        strobe.writeBack = 1'b1;
        nextState        = S_IDLE;
        case (status.descDt)
          DT_INVALID: begin
            strobe.finish = 1'b1;
            strobe.fault  = FLT_INVALID;
          end
          DT_PAGE: begin
            strobe.finish = 1'b1;
            if (status.supBad)     strobe.fault = FLT_SUPER;
            else if (status.wpBad) strobe.fault = FLT_WPROT;
            else begin
              strobe.physSel = PH_PAGE;
              strobe.setMod  = status.isWrite;
            end
          end
          default: begin
            if (status.lastLevel) begin
              strobe.finish = 1'b1;
              strobe.fault  = FLT_INVALID;
            end else begin
              strobe.descend = 1'b1;
              nextState      = S_ISSUE;
            end
          end
        endcase
      end
      default: nextState = S_IDLE;
    endcase
  end

endmodule

// File: rtl/walk_datapath.sv
module walk_datapath
  import walk_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEVELS  = 4,
  parameter int FIELD_W = 4,
  parameter int LIMIT_W = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  output status_t             status,
  input  logic [ADDR_W-1:0]   ctrlWord,
  input  logic [2*ADDR_W-1:0] userRoot,
  input  logic [2*ADDR_W-1:0] superRoot,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqWrite,
  input  logic                reqSuper,
  output logic [ADDR_W-1:0]   memRdAddr,
  input  logic [ADDR_W-1:0]   memRdData,
  output logic                memWrEn,
  output logic [ADDR_W-1:0]   memWrAddr,
  output logic [ADDR_W-1:0]   memWrData,
  output logic                rspValid,
  output logic [ADDR_W-1:0]   rspPhys,
  output logic [3:0]          rspFault,
  output logic                rspWp,
  output logic                rspCi
);

  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int POS_W = $clog2(ADDR_W) + 3;
  localparam int IS_LSB = LEVELS * FIELD_W;
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ~ADDR_W'((1 << PAGE_LSB) - 1);
  localparam logic [ADDR_W-1:0] TBL_MASK  = ~ADDR_W'((1 << TBL_LSB) - 1);

  logic [ADDR_W-1:0]  vAddr, cfg, tBase, word0, word1;
  logic               isWrite, isSuper, longFmt, wpAcc, supAcc, limLower;
  logic [LIMIT_W-1:0] limVal;
  logic [LVL_W-1:0]   level, nxtLevel;

  logic [FIELD_W-1:0] lvlWidth [LEVELS];
  logic [POS_W-1:0]   lvlStart [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : gWidth
    assign lvlWidth[g] = cfg[(LEVELS-1-g)*FIELD_W +: FIELD_W];
  end

  always_comb begin
    logic [POS_W-1:0] acc;
    acc = POS_W'(cfg[IS_LSB +: FIELD_W]);
    for (int i = 0; i < LEVELS; i++) begin
      lvlStart[i] = acc;
      acc = acc + POS_W'(lvlWidth[i]);
    end
  end

  logic [FIELD_W-1:0]  curWidth, nextWidth;
  logic [POS_W-1:0]    curStart, curEnd, remBits;
  logic [ADDR_W-1:0]   shifted, idx, entryAddr, lowMask, addrField, pagePhys;
  logic [ADDR_W-1:0]   wbData;
  logic [2*ADDR_W-1:0] rootLive;
  logic [ADDR_W-1:0]   rootBase;
  logic                newWp, newSup;

  assign curWidth  = lvlWidth[level];
  assign curStart  = lvlStart[level];
  assign nxtLevel  = level + 1'b1;
  assign nextWidth = (level == LAST_LVL) ? '0 : lvlWidth[nxtLevel];
  assign shifted   = vAddr << curStart;
  assign idx       = (curWidth == '0) ? '0
                   : shifted >> (POS_W'(ADDR_W) - POS_W'(curWidth));
  assign entryAddr = tBase + (longFmt ? (idx << 3) : (idx << 2));
  assign memRdAddr = strobe.rdWord1 ? entryAddr + ADDR_W'(4) : entryAddr;

  assign curEnd  = curStart + POS_W'(curWidth);
  assign remBits = (curEnd >= POS_W'(ADDR_W)) ? '0 : POS_W'(ADDR_W) - curEnd;
  assign lowMask = (remBits >= POS_W'(ADDR_W)) ? '1
                 : ((ADDR_W'(1) << remBits) - ADDR_W'(1));

  assign addrField = longFmt ? word1 : word0;
  assign pagePhys  = (addrField & PAGE_MASK) + (vAddr & lowMask);
  assign newWp     = wpAcc | word0[BIT_WP];
  assign newSup    = supAcc | (longFmt & word0[BIT_SUP]);

  assign rootLive = reqSuper ? superRoot : userRoot;
  assign rootBase = rootLive[ADDR_W-1:0] & TBL_MASK;

  always_comb begin
    wbData = word0;
    wbData[BIT_USED] = 1'b1;
    if (strobe.setMod) wbData[BIT_MOD] = 1'b1;
  end

  assign memWrEn   = strobe.writeBack && (wbData != word0);
  assign memWrAddr = entryAddr;
  assign memWrData = wbData;

  always_comb begin
    status.enable    = ctrlWord[ADDR_W-1];
    status.rootDt    = rootLive[ADDR_W +: 2];
    status.limitBad  = limLower ? (idx < ADDR_W'(limVal)) : (idx > ADDR_W'(limVal));
    status.longFmt   = longFmt;
    status.descDt    = word0[1:0];
    status.lastLevel = (nextWidth == '0);
    status.supBad    = newSup & ~isSuper;
    status.wpBad     = newWp & isWrite;
    status.isWrite   = isWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vAddr <= '0; cfg <= '0; tBase <= '0; word0 <= '0; word1 <= '0;
      isWrite <= 1'b0; isSuper <= 1'b0; longFmt <= 1'b0;
      wpAcc <= 1'b0; supAcc <= 1'b0; limLower <= 1'b0;
      limVal <= '1; level <= '0;
    end else begin
      if (strobe.load) begin
        vAddr    <= reqAddr;
        cfg      <= ctrlWord;
        isWrite  <= reqWrite;
        isSuper  <= reqSuper;
        tBase    <= rootBase;
        longFmt  <= rootLive[ADDR_W];
        limVal   <= rootLive[2*ADDR_W-2 -: LIMIT_W];
        limLower <= rootLive[2*ADDR_W-1];
        level    <= '0;
        wpAcc    <= 1'b0;
        supAcc   <= 1'b0;
      end
      if (strobe.capW0) word0 <= memRdData;
      if (strobe.capW1) word1 <= memRdData;
      if (strobe.descend) begin
        tBase   <= addrField & TBL_MASK;
        longFmt <= word0[0];
        level   <= nxtLevel;
        wpAcc   <= newWp;
        supAcc  <= newSup;
        if (longFmt) begin
          limVal   <= word0[ADDR_W-2 -: LIMIT_W];
          limLower <= word0[ADDR_W-1];
        end else begin
          limVal   <= '1;
          limLower <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0; rspPhys <= '0; rspFault <= '0;
      rspWp <= 1'b0; rspCi <= 1'b0;
    end else begin
      rspValid <= strobe.finish;
      if (strobe.finish) begin
        rspFault <= strobe.fault;
        rspWp    <= (strobe.physSel == PH_PAGE) & newWp;
        rspCi    <= (strobe.physSel == PH_PAGE) & word0[BIT_CI];
        case (strobe.physSel)
          PH_PASS: rspPhys <= reqAddr;
          PH_ROOT: rspPhys <= rootBase + reqAddr;
          PH_PAGE: rspPhys <= pagePhys;
          default: rspPhys <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/table_walker.sv
module table_walker
  import walk_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEVELS  = 4,
  parameter int FIELD_W = 4,
  parameter int LIMIT_W = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   ctrlWord,
  input  logic [2*ADDR_W-1:0] userRoot,
  input  logic [2*ADDR_W-1:0] superRoot,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqWrite,
  input  logic                reqSuper,
  output logic                rspValid,
  output logic [ADDR_W-1:0]   rspPhys,
  output logic [3:0]          rspFault,
  output logic                rspWp,
  output logic                rspCi,
  output logic                memRdEn,
  output logic [ADDR_W-1:0]   memRdAddr,
  input  logic [ADDR_W-1:0]   memRdData,
  output logic                memWrEn,
  output logic [ADDR_W-1:0]   memWrAddr,
  output logic [ADDR_W-1:0]   memWrData
);

  strobe_t strobe;
  status_t status;

  walk_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .status(status), .strobe(strobe), .reqReady(reqReady)
  );

  walk_datapath #(
    .ADDR_W(ADDR_W), .LEVELS(LEVELS), .FIELD_W(FIELD_W), .LIMIT_W(LIMIT_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .status(status),
    .ctrlWord(ctrlWord), .userRoot(userRoot), .superRoot(superRoot),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqSuper(reqSuper),
    .memRdAddr(memRdAddr), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .rspValid(rspValid), .rspPhys(rspPhys), .rspFault(rspFault),
    .rspWp(rspWp), .rspCi(rspCi)
  );

  assign memRdEn = strobe.rdWord0 | strobe.rdWord1;

endmodule

// File: rtl/walk_checker.sv
module walk_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [ADDR_W-1:0] ctrlWord,
  input logic              rspValid,
  input logic [ADDR_W-1:0] rspPhys,
  input logic [3:0]        rspFault,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memRdAddr,
  input logic              memWrEn,
  input logic [ADDR_W-1:0] memWrData
);

  AST_PASS_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !ctrlWord[ADDR_W-1]) |=>
    (rspValid && rspPhys == $past(reqAddr) && rspFault == 4'b0)); // R1

  AST_FAULT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $onehot0(rspFault)); // R11

  AST_FAULT_ZERO_PHYS: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != 4'b0) |-> (rspPhys == '0)); // R11

  AST_IDLE_ON_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> reqReady); // R11

  AST_BUSY_WHILE_READING: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> !reqReady); // R11

  AST_RD_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (memRdAddr[1:0] == 2'b00)); // R3

  AST_WB_MARKS_USED: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> memWrData[3]); // R10

  AST_PORTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(memWrEn && memRdEn)); // R10

endmodule

bind table_walker walk_checker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqAddr(reqAddr), .ctrlWord(ctrlWord), .rspValid(rspValid),
  .rspPhys(rspPhys), .rspFault(rspFault), .memRdEn(memRdEn),
  .memRdAddr(memRdAddr), .memWrEn(memWrEn), .memWrData(memWrData)
);

// File: tb/sim_table_walker.sv
`timescale 1ns/1ps
module sim_table_walker;

  localparam int MEM_WORDS = 1024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] ctrlWord = '0;
  logic [63:0] userRoot = '0, superRoot = '0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqSuper = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqReady, rspValid, rspWp, rspCi, memRdEn, memWrEn;
  logic [31:0] rspPhys, memRdAddr, memWrAddr, memWrData;
  logic [31:0] memRdData = '0;
  logic [3:0]  rspFault;

  logic [31:0] mem    [MEM_WORDS];
  logic [31:0] refMem [MEM_WORDS];

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  table_walker u0 (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .userRoot(userRoot),
    .superRoot(superRoot), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqSuper(reqSuper),
    .rspValid(rspValid), .rspPhys(rspPhys), .rspFault(rspFault),
    .rspWp(rspWp), .rspCi(rspCi), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .memRdData(memRdData), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .memWrData(memWrData)
  );

  always @(posedge clk) begin
    if (memWrEn) mem[memWrAddr[11:2]] <= memWrData;
    if (memRdEn) memRdData <= mem[memRdAddr[11:2]];
  end

  typedef struct packed {
    logic [31:0] phys;
    logic [3:0]  fault;
    logic        wp;
    logic        ci;
  } exp_t;

  exp_t got;
  logic readyAfter, rspAtFirst;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    finishRun();
  end

  function automatic logic [31:0] lowMaskOf(input int endPos);
    int rem;
    rem = (endPos >= 32) ? 0 : 32 - endPos;
    return (rem >= 32) ? 32'hFFFF_FFFF : ((32'd1 << rem) - 32'd1);
  endfunction

  // Reference walk over refMem, applying the same used/modified updates.
  function automatic exp_t refWalk(input logic [31:0] a, input logic wr,
                                   input logic sup, input logic [31:0] cfg,
                                   input logic [63:0] ur, input logic [63:0] sr);
    logic [63:0] root;
    logic [31:0] base, w0, w1, af, ea, idx, nw;
    logic        lng, lower, wp, sp;
    logic [14:0] lim;
    logic [3:0]  f;
    int          start, w, nextw;
    exp_t        e;
    e = '0;
    root = sup ? sr : ur;
    if (!cfg[31]) begin e.phys = a; return e; end
    if (root[33:32] == 2'b00) begin e.fault = 4'b0001; return e; end
    if (root[33:32] == 2'b01) begin e.phys = {root[31:4], 4'h0} + a; return e; end
    base = {root[31:4], 4'h0}; lng = root[32]; lim = root[62:48]; lower = root[63];
    wp = 1'b0; sp = 1'b0; start = int'(cfg[19:16]);
    for (int lvl = 0; lvl < 4; lvl++) begin
      w = int'(cfg[(3-lvl)*4 +: 4]);
      idx = (w == 0) ? 32'd0 : ((a << start) >> (32 - w));
      if (lower ? (idx < {17'd0, lim}) : (idx > {17'd0, lim})) begin
        e.fault = 4'b0010; return e;
      end
      ea = base + (lng ? idx * 8 : idx * 4);
      w0 = refMem[ea[11:2]];
      w1 = refMem[(ea + 32'd4) >> 2 & 32'h3FF];
      wp = wp | w0[2];
      if (lng) sp = sp | w0[8];
      af = lng ? w1 : w0;
      nw = w0 | 32'h8;
      case (w0[1:0])
        2'b00: begin refMem[ea[11:2]] = nw; e.fault = 4'b0001; return e; end
        2'b01: begin
          f = (sp && !sup) ? 4'b0100 : (wp && wr) ? 4'b1000 : 4'b0000;
          if (f == 4'b0 && wr) nw = nw | 32'h10;
          refMem[ea[11:2]] = nw;
          if (f != 4'b0) begin e.fault = f; return e; end
          e.phys = {af[31:8], 8'h0} + (a & lowMaskOf(start + w));
          e.wp = wp; e.ci = w0[6];
          return e;
        end
        default: begin
          refMem[ea[11:2]] = nw;
          nextw = (lvl == 3) ? 0 : int'(cfg[(2-lvl)*4 +: 4]);
          if (nextw == 0) begin e.fault = 4'b0001; return e; end
          base = {af[31:4], 4'h0};
          lim = lng ? w0[30:16] : 15'h7FFF;
          lower = lng ? w0[31] : 1'b0;
          lng = w0[0];
          start = start + w;
        end
      endcase
    end
    return e;
  endfunction

  task automatic poke(input logic [31:0] addr, input logic [31:0] val);
    mem[addr[11:2]] = val;
    refMem[addr[11:2]] = val;
  endtask

  task automatic doTxn(input logic [31:0] a, input logic wr, input logic sup);
    int n;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqWrite = wr; reqSuper = sup;
    @(negedge clk);
    reqValid = 1'b0;
    readyAfter = reqReady;
    rspAtFirst = rspValid;
    n = 0;
    while (!rspValid && n < 64) begin @(negedge clk); n++; end
    got.phys = rspPhys; got.fault = rspFault; got.wp = rspWp; got.ci = rspCi;
  endtask

  task automatic runTxn(input string tag, input logic [31:0] a, input logic wr,
                        input logic sup);
    exp_t e;
    int bad;
    e = refWalk(a, wr, sup, ctrlWord, userRoot, superRoot);
    doTxn(a, wr, sup);
    chk({tag, " result"}, {24'd0, got}, {24'd0, e});
    bad = 0;
    for (int i = 0; i < MEM_WORDS; i++) if (mem[i] !== refMem[i]) bad++;
    chk({tag, " R10 memory"}, 64'(bad), 64'd0);
    for (int i = 0; i < MEM_WORDS; i++) refMem[i] = mem[i];
  endtask

  localparam logic [31:0] CFG2 = 32'h8008_4400;
  localparam logic [63:0] ROOT_S = 64'h7FFF_0002_0000_0100;

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < MEM_WORDS; i++) begin mem[i] = '0; refMem[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R11 reset ready", {63'd0, reqReady}, 64'd1);
    chk("R11 reset rsp", {63'd0, rspValid}, 64'd0);
    chk("R11 reset rd", {63'd0, memRdEn}, 64'd0);
    rstN = 1'b1;

    // R1 pass-through
    ctrlWord = 32'h0008_4400;
    runTxn("R1 pass", 32'h1234_5678, 1'b0, 1'b0);
    chk("R1 phys", {32'd0, got.phys}, 64'h1234_5678);
    chk("R1 latency", {62'd0, rspAtFirst, readyAfter}, 64'd3);

    // R2 root types
    ctrlWord = CFG2;
    userRoot = 64'h7FFF_0001_0010_0000;
    runTxn("R2 root page", 32'h0000_0345, 1'b0, 1'b0);
    chk("R2 root page phys", {32'd0, got.phys}, 64'h0010_0345);
    superRoot = 64'h7FFF_0000_0000_0000;
    runTxn("R2 root invalid", 32'h0000_0345, 1'b0, 1'b1);
    chk("R2 root invalid fault", {60'd0, got.fault}, 64'h1);

    // R3/R12 two-level walk with short entries
    userRoot = ROOT_S; superRoot = ROOT_S;
    poke(32'h10C, 32'h0000_0202);
    poke(32'h214, 32'hABCD_E141);
    runTxn("R3 two level", 32'h0035_0ABC, 1'b0, 1'b0);
    chk("R3 phys", {32'd0, got.phys}, 64'hABCD_EBBC);
    chk("R12 ci", {63'd0, got.ci}, 64'd1);
    chk("R11 busy", {63'd0, readyAfter}, 64'd0);
    chk("R10 used A", {32'd0, mem[32'h10C >> 2]}, 64'h20A);

    // R4 early end at level A
    poke(32'h110, 32'h0300_0001);
    runTxn("R4 early", 32'h0041_2345, 1'b0, 1'b0);
    chk("R4 phys", {32'd0, got.phys}, 64'h0301_2345);

    // R10 modified on write
    runTxn("R10 write", 32'h0035_0ABC, 1'b1, 1'b0);
    chk("R10 modified", {32'd0, mem[32'h214 >> 2]}, 64'hABCD_E159);

    // R8 write-protect
    poke(32'h114, 32'h0000_0206);
    runTxn("R8 wp read", 32'h0055_0ABC, 1'b0, 1'b0);
    chk("R8 wp flag", {63'd0, got.wp}, 64'd1);
    runTxn("R8 wp write", 32'h0055_0ABC, 1'b1, 1'b0);
    chk("R8 wp fault", {60'd0, got.fault}, 64'h8);

    // R6 bounds
    userRoot = 64'h0004_0002_0000_0100;
    runTxn("R6 upper", 32'h0055_0ABC, 1'b0, 1'b0);
    chk("R6 upper fault", {60'd0, got.fault}, 64'h2);
    userRoot = 64'h8003_0002_0000_0100;
    runTxn("R6 lower pass", 32'h0041_2345, 1'b0, 1'b0);
    chk("R6 lower pass phys", {32'd0, got.phys}, 64'h0301_2345);
    runTxn("R6 lower", 32'h0025_0000, 1'b0, 1'b0);
    chk("R6 lower fault", {60'd0, got.fault}, 64'h2);

    // R5/R9 long entries, supervisor mark
    userRoot = 64'h7FFF_0003_0000_0400; superRoot = userRoot;
    poke(32'h418, 32'h0000_0101);
    poke(32'h41C, 32'h0500_0000);
    runTxn("R9 user", 32'h0035_0ABC, 1'b0, 1'b0);
    chk("R9 sup fault", {60'd0, got.fault}, 64'h4);
    runTxn("R5 super", 32'h0035_0ABC, 1'b0, 1'b1);
    chk("R5 long phys", {32'd0, got.phys}, 64'h0505_0ABC);
    poke(32'h418, 32'h0000_010D);
    runTxn("R9 priority", 32'h0035_0ABC, 1'b1, 1'b0);
    chk("R9 priority fault", {60'd0, got.fault}, 64'h4);
    runTxn("R8 long wp", 32'h0035_0ABC, 1'b1, 1'b1);
    chk("R8 long wp fault", {60'd0, got.fault}, 64'h8);

    // R7 invalid entries
    userRoot = ROOT_S;
    runTxn("R7 invalid", 32'h0070_0000, 1'b0, 1'b0);
    chk("R7 invalid fault", {60'd0, got.fault}, 64'h1);
    poke(32'h218, 32'h0000_0302);
    runTxn("R7 table at last", 32'h0036_0000, 1'b0, 1'b0);
    chk("R7 last fault", {60'd0, got.fault}, 64'h1);
    chk("R11 fault phys", {32'd0, got.phys}, 64'd0);

    // R3 random trees and configurations
    for (int t = 0; t < 300; t++) begin
      if (t % 20 == 0)
        for (int i = 0; i < MEM_WORDS; i++) poke(32'(i * 4), $urandom);
      if (t % 5 == 0) begin
        int is_, ta, tb, tc, td, sel;
        logic [63:0] r;
        is_ = $urandom % 9; ta = 1 + $urandom % 6; tb = $urandom % 7;
        tc = (tb != 0) ? $urandom % 6 : 0; td = (tc != 0) ? $urandom % 5 : 0;
        ctrlWord = {($urandom % 8 != 0), 7'd0, 4'd8, 4'(is_), 4'(ta), 4'(tb), 4'(tc), 4'(td)};
        for (int k = 0; k < 2; k++) begin
          sel = $urandom % 8;
          r = '0;
          r[31:0] = $urandom & 32'h0000_0FF0;
          r[33:32] = (sel == 0) ? 2'b00 : (sel == 1) ? 2'b01 : (sel < 5) ? 2'b10 : 2'b11;
          if ($urandom % 4 == 0) begin r[62:48] = 15'($urandom); r[63] = 1'($urandom); end
          else r[62:48] = 15'h7FFF;
          if (k == 0) userRoot = r; else superRoot = r;
        end
      end
      runTxn("R3 random", $urandom, 1'($urandom), 1'($urandom));
    end

    finishRun();
  end

endmodule